// File: doc/BRIEF.md
# Serial Configuration Latch Loader

This block takes configuration words from a three-wire serial port (a bit clock, a data line and a load strobe) and turns them into four parallel configuration registers for the rest of a frequency synthesizer. While the load strobe is low, each rising edge of the bit clock shifts one data bit into a 24-bit word, the most significant bit first. A rising edge of the load strobe then copies that word into one of four holding latches. The two least significant bits of the word select the latch.

The three serial wires are asynchronous to the system clock. Each wire passes through its own synchronizer chain, and the edges are detected in the system clock domain. Each latch keeps the 22 bits above the two select bits. It holds that value until a later load addresses it. The latches drive the reference divider, the feedback divider, the function controls and the initialization controls.

Top module: `slp_top`

## Requirements
- R1: After reset all four latch outputs are zero.
- R2: Bits are taken on rising edges of the serial clock, the first bit becoming the most significant bit of the word; a latch receives word bits 23 down to 2 with bit 23 at the latch's top.
- R3: A load strobe rising edge with word bits [1:0] = 00 updates `refLatch` with the word's upper 22 bits.
- R4: Select code 01 updates `nLatch`.
- R5: Select code 10 updates `funcLatch`.
- R6: Select code 11 updates `initLatch`.
- R7: A load changes only the addressed latch; the other three hold their values.
- R8: When more than 24 bits are clocked before a load, only the last 24 bits form the word.
- R9: Shifting bits without a rising edge of the load strobe leaves all four latches unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock, asynchronous |
| serData | input | 1 | Serial data bit, asynchronous |
| serLoad | input | 1 | Load strobe, asynchronous; its rising edge transfers the word |
| refLatch | output | 22 | Reference-divider latch (select 00) |
| nLatch | output | 22 | Feedback-divider latch (select 01) |
| funcLatch | output | 22 | Function latch (select 10) |
| initLatch | output | 22 | Initialization latch (select 11) |

## Verification
The bench uses a word width of 24 and a three-stage synchronizer. The deeper chain exercises the parameterized synchronizer, and its extra latency must be hidden by the serial timing. Each serial phase is held for several system clocks, so every bit and every load edge passes through the synchronizers no matter how deep they are. This makes runs of 30 bits, shifting without a load, and every select code testable against a bench-side model of the shift register.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int SEL_W = 2;
  localparam int NUM_LATCH = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_REF  = 2'b00,
    SEL_N    = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_INIT = 2'b11
  } latchSel_e;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadEn;
  } strobe_t;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serData,
  input  logic    serLoad,
  output strobe_t strb
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pinSync;
  logic             clkPrev;
  logic             loadPrev;

  slp_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({serLoad, serData, serClk}),
    .syncOut(pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
      strb     <= '0;
    end else begin
      clkPrev       <= pinSync[0];
      loadPrev      <= pinSync[2];
      strb.shiftEn  <= pinSync[0] & ~clkPrev;
      strb.shiftBit <= pinSync[1];
      strb.loadEn   <= pinSync[2] & ~loadPrev;
    end
  end
endmodule

// File: rtl/slp_dpath.sv
module slp_dpath
  import slp_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int PAY_W = WORD_W - SEL_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strb,
  output logic [WORD_W-1:0]              shiftWord,
  output logic [NUM_LATCH-1:0][PAY_W-1:0] latches
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftWord <= '0;
    else if (strb.shiftEn) shiftWord <= {shiftWord[WORD_W-2:0], strb.shiftBit};
  end

  for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
    logic [PAY_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (strb.loadEn && shiftWord[SEL_W-1:0] == SEL_W'(g))
        q <= shiftWord[WORD_W-1:SEL_W];
    end
    assign latches[g] = q;
  end
endmodule

// File: rtl/slp_top.sv
module slp_top
  import slp_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2,
  localparam int PAY_W      = WORD_W - SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serData,
  input  logic             serLoad,
  output logic [PAY_W-1:0] refLatch,
  output logic [PAY_W-1:0] nLatch,
  output logic [PAY_W-1:0] funcLatch,
  output logic [PAY_W-1:0] initLatch
);
  strobe_t                         strb;
  logic [WORD_W-1:0]               shiftWord;
  logic [NUM_LATCH-1:0][PAY_W-1:0] latches;

  slp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serData(serData),
    .serLoad(serLoad),
    .strb   (strb)
  );

  slp_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .shiftWord(shiftWord),
    .latches  (latches)
  );

  assign refLatch  = latches[SEL_REF];
  assign nLatch    = latches[SEL_N];
  assign funcLatch = latches[SEL_FUNC];
  assign initLatch = latches[SEL_INIT];
endmodule

// File: rtl/slp_chk.sv
module slp_chk
  import slp_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int PAY_W = WORD_W - SEL_W
) (
  input logic              clk,
  input logic              rstN,
  input strobe_t           strb,
  input logic [WORD_W-1:0] shiftWord,
  input logic [PAY_W-1:0]  refLatch,
  input logic [PAY_W-1:0]  nLatch,
  input logic [PAY_W-1:0]  funcLatch,
  input logic [PAY_W-1:0]  initLatch
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (refLatch == '0 && nLatch == '0 && funcLatch == '0 && initLatch == '0));

  // R3
  ref_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && shiftWord[1:0] == 2'b00) |=> refLatch == $past(shiftWord[WORD_W-1:SEL_W]));

  // R4
  n_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && shiftWord[1:0] == 2'b01) |=> nLatch == $past(shiftWord[WORD_W-1:SEL_W]));

  // R5
  func_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && shiftWord[1:0] == 2'b10) |=> funcLatch == $past(shiftWord[WORD_W-1:SEL_W]));

  // R6
  init_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && shiftWord[1:0] == 2'b11) |=> initLatch == $past(shiftWord[WORD_W-1:SEL_W]));

  // R7
  one_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({refLatch != $past(refLatch), nLatch != $past(nLatch),
                funcLatch != $past(funcLatch), initLatch != $past(initLatch)}) <= 1);

  // R9
  no_load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> ($stable(refLatch) && $stable(nLatch) && $stable(funcLatch) && $stable(initLatch)));
endmodule

bind slp_top slp_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .shiftWord(shiftWord),
  .refLatch (refLatch),
  .nLatch   (nLatch),
  .funcLatch(funcLatch),
  .initLatch(initLatch)
);

// File: tb/sim_slp_top.sv
`timescale 1ns/1ps
module sim_slp_top;
  localparam int WORD_W = 24;
  localparam int PAY_W  = WORD_W - 2;
  localparam int HOLD   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0;
  logic [PAY_W-1:0] refLatch, nLatch, funcLatch, initLatch;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [WORD_W-1:0] shadow = '0;
  logic [PAY_W-1:0] expL [4];

  always #2.5 clk = ~clk;

  slp_top #(.WORD_W(WORD_W), .SYNC_STAGES(3)) u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .refLatch(refLatch), .nLatch(nLatch), .funcLatch(funcLatch), .initLatch(initLatch)
  );

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBits(logic [31:0] val, int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = val[i];
      waitClk(HOLD);
      serClk = 1'b1;
      waitClk(HOLD);
      serClk = 1'b0;
      shadow = {shadow[WORD_W-2:0], val[i]};
    end
  endtask

  task automatic pulseLoad();
    waitClk(HOLD);
    serLoad = 1'b1;
    waitClk(HOLD);
    serLoad = 1'b0;
    waitClk(HOLD);
    expL[shadow[1:0]] = shadow[WORD_W-1:2];
  endtask

  function automatic logic [PAY_W-1:0] actual(int i);
    case (i)
      0: return refLatch;
      1: return nLatch;
      2: return funcLatch;
      default: return initLatch;
    endcase
  endfunction

  task automatic checkOne(string tag, int i);
    checks++;
    if (actual(i) !== expL[i]) begin
      failures++;
      $display("FAIL %s latch%0d actual=%h expected=%h", tag, i, actual(i), expL[i]);
    end
  endtask

  task automatic checkAll(string tag);
    for (int i = 0; i < 4; i++) checkOne(tag, i);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) expL[i] = '0;
    void'($urandom(32'd5150));
    waitClk(4);
    checkAll("R1");
    rstN = 1'b1;
    waitClk(6);
    checkAll("R1");

    // R2: MSB-first pattern into the reference latch
    shiftBits(32'hA5C3F0, 24); pulseLoad();
    checkOne("R2", 0);
    // R3..R6: each select code, R7 others held
    shiftBits(32'h123458, 24); pulseLoad(); checkOne("R3", 0); checkAll("R7");
    shiftBits(32'hFEDCB9, 24); pulseLoad(); checkOne("R4", 1); checkAll("R7");
    shiftBits(32'h0F0F0E, 24); pulseLoad(); checkOne("R5", 2); checkAll("R7");
    shiftBits(32'hC0FFEF, 24); pulseLoad(); checkOne("R6", 3); checkAll("R7");

    // R8: 30 bits before the load, only the last 24 count
    shiftBits(32'h3F5A5A55, 30); pulseLoad(); checkAll("R8");
    shiftBits(32'h2AFFFFFE, 30); pulseLoad(); checkAll("R8");

    // R9: shifting without a load edge changes nothing
    shiftBits(32'h777776, 24);
    waitClk(3 * HOLD);
    checkAll("R9");

    for (int k = 0; k < 40; k++) begin
      int n;
      n = 24 + int'($urandom_range(0, 6));
      shiftBits($urandom, n);
      if ($urandom_range(0, 4) == 0) begin
        waitClk(3 * HOLD);
        checkAll("R9");
      end else begin
        pulseLoad();
        checkAll("R7");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule